// File: doc/BRIEF.md
# Shared-Queue Packet Dispatcher

This block sits in front of a group of worker cores. It gathers 32-bit packet words from a single source into one common FIFO. It then hands the words out, one per clock at most, to whichever cores are asking for work. Each core has its own request line. When more than one core asks in the same cycle, the core with the lowest index is served first.

The granted word is steered to the winning core's data lane, and that lane's valid flag rises in the next cycle. All other lanes read zero and their valid flags stay low.

The source watches a full flag. A word offered while the FIFO is full is discarded, and a wrapping counter records how many words were discarded. Because all cores share one queue, the block can never deliver more than one packet per clock, however many cores are idle.

Top module: `shq_dispatch`

## Requirements
- R1: A word with `in_valid` high is stored whenever `q_full` is low, one word per cycle, and words reach the cores in the order they arrived.
- R2: A request is served only if the FIFO held a word at the start of that cycle. A request made while the FIFO is empty is not granted, even if a word is pushed in that same cycle. The core must hold the request, and it is served in a later cycle once a word is present.
- R3: At most one core receives a word per clock, so `core_valid` is zero or one-hot.
- R4: When several cores request in the same cycle, the lowest-indexed requester is granted.
- R5: A word granted in cycle t appears in cycle t+1 on the granted core's lane, bits [32*i+31:32*i] of `core_data`, with `core_valid[i]` high. Every lane that is not being served reads zero.
- R6: `q_full` is high exactly when DEPTH words are held (DEPTH = 16 by default). A word offered while `q_full` is high is dropped, even if a pop happens in that cycle. `drop_cnt` rises by one for each dropped word and wraps.
- R7: A push and a pop in the same cycle on a non-empty FIFO leave its occupancy unchanged.
- R8: Each grant produces a single-cycle `core_valid` pulse. The served core must have its request low in the cycle in which its `core_valid` is high.
- R9: After synchronous active-low reset, the FIFO is empty, `q_full` is low, `drop_cnt` is zero and every `core_valid` and lane is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 32 | Packet word from the source |
| in_valid | input | 1 | Qualifies `in_data` |
| q_full | output | 1 | FIFO holds DEPTH words; further words are dropped |
| core_req | input | N_CORES | One request line per worker core |
| core_data | output | 32*N_CORES | Per-core data lanes, core i at bits [32*i+31:32*i] |
| core_valid | output | N_CORES | Per-core delivery strobe |
| drop_cnt | output | DROP_W | Wrapping count of words dropped while full |

## Verification
The checks take for granted that a core lowers its request in the cycle in which its word arrives. Only under that condition can each grant map to exactly one delivery. Every stimulus pattern follows that rule: a core whose lane is valid always shows a low request, and the drain phase alternates between two cores so that no core requests twice in a row. Otherwise, the requests, the pushes and the full condition are driven freely, including pushes into an empty queue with a request present, and pushes while full during a pop.

// File: rtl/shq_pkg.sv
// Shared definitions for the shared-queue dispatcher.
// Assumes one word width for the whole group of cores.
package shq_pkg;
    parameter int unsigned SHQ_WORD_W = 32;
    typedef logic [SHQ_WORD_W-1:0] shq_word_t;
endpackage

// File: rtl/shq_fifo.sv
// Synchronous FIFO with a head-of-queue read port and an occupancy count.
// Assumes the parent pushes only when not full and pops only when not empty.
module shq_fifo
    import shq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  shq_word_t                    din,
    output shq_word_t                    head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    shq_word_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Head word and status flags.
    always_comb begin
        head  = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CMAX);
    end
endmodule

// File: rtl/shq_arbiter.sv
// Fixed-priority arbiter: lowest-indexed active request wins.
// Assumes no grant is wanted while enable is low.
module shq_arbiter #(
    parameter int unsigned N  = 4,
    parameter int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic          enable,
    output logic          any,
    output logic [SW-1:0] sel
);
    // Scan from the top so the lowest index is written last.
    always_comb begin
        sel = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (req[i]) sel = SW'(i);
        end
        any = enable && (|req);
    end
endmodule

// File: rtl/shq_demux.sv
// Registered demultiplexer: steers one word and its strobe to a selected lane.
// Assumes sel is in range whenever go is high.
module shq_demux
    import shq_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic [SW-1:0]            sel,
    input  shq_word_t                word,
    output logic [N*SHQ_WORD_W-1:0]  lane_data,
    output logic [N-1:0]             lane_valid
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic hit;
        assign hit = go && (sel == SW'(g));
        // Per-lane output register; idle lanes are held at zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_valid[g]                           <= 1'b0;
                lane_data[g*SHQ_WORD_W +: SHQ_WORD_W]   <= '0;
            end else begin
                lane_valid[g]                           <= hit;
                lane_data[g*SHQ_WORD_W +: SHQ_WORD_W]   <= hit ? word : '0;
            end
        end
    end
endmodule

// File: rtl/shq_dispatch.sv
// Shared-queue dispatcher: one FIFO feeds N cores, one delivery per clock.
// Assumes a served core drops its request in the cycle its word arrives.
module shq_dispatch
    import shq_pkg::*;
#(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned DROP_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [SHQ_WORD_W-1:0]           in_data,
    input  logic                            in_valid,
    output logic                            q_full,
    input  logic [N_CORES-1:0]              core_req,
    output logic [N_CORES*SHQ_WORD_W-1:0]   core_data,
    output logic [N_CORES-1:0]              core_valid,
    output logic [DROP_W-1:0]               drop_cnt
);
    localparam int unsigned SW = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);

    shq_word_t        head;
    logic [CW-1:0]    count;
    logic             empty, push_ok, pop_ok;
    logic [SW-1:0]    sel;

    assign push_ok = in_valid && !q_full;

    shq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok),
        .din(in_data), .head(head), .count(count), .empty(empty), .full(q_full)
    );

    shq_arbiter #(.N(N_CORES), .SW(SW)) u_arb (
        .req(core_req), .enable(!empty), .any(pop_ok), .sel(sel)
    );

    shq_demux #(.N(N_CORES), .SW(SW)) u_demux (
        .clk(clk), .rst_n(rst_n), .go(pop_ok), .sel(sel), .word(head),
        .lane_data(core_data), .lane_valid(core_valid)
    );

    // Count words refused because the queue was full.
    always_ff @(posedge clk) begin
        if (!rst_n)                  drop_cnt <= '0;
        else if (in_valid && q_full) drop_cnt <= drop_cnt + 1'b1;
    end
endmodule

// File: rtl/shq_dispatch_chk.sv
// Property checker for shq_dispatch, attached by bind.
module shq_dispatch_chk #(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned W       = 32,
    parameter int unsigned DROP_W  = 8,
    parameter int unsigned CW      = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  q_full,
    input logic [N_CORES-1:0]    core_req,
    input logic [N_CORES*W-1:0]  core_data,
    input logic [N_CORES-1:0]    core_valid,
    input logic [DROP_W-1:0]     drop_cnt,
    input logic                  empty,
    input logic                  push_ok,
    input logic                  pop_ok,
    input logic [CW-1:0]         count
);
    // R3
    one_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_valid));

    // R2
    empty_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && |core_req) |=> (core_valid == '0));

    // R2
    ready_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && |core_req) |=> (|core_valid));

    // R6
    drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q_full) |=> (drop_cnt == $past(drop_cnt) + 1'b1));

    // R7
    occupancy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));

    for (genvar g = 0; g < N_CORES; g++) begin : g_lane_chk
        // R5
        idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !core_valid[g] |-> (core_data[g*W +: W] == '0));

        // R8
        req_withdrawn_chk: assert property (@(posedge clk) disable iff (!rst_n)
            core_valid[g] |-> !core_req[g]);

        if (g > 0) begin : g_prio
            // R4
            lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                core_valid[g] |-> (($past(core_req) & N_CORES'((1 << g) - 1)) == '0));
        end
    end
endmodule

bind shq_dispatch shq_dispatch_chk #(
    .N_CORES(N_CORES), .W(shq_pkg::SHQ_WORD_W), .DROP_W(DROP_W), .CW($clog2(DEPTH+1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .q_full(q_full),
    .core_req(core_req), .core_data(core_data), .core_valid(core_valid),
    .drop_cnt(drop_cnt), .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok),
    .count(count)
);

// File: tb/tb_shq_dispatch.sv
module tb_shq_dispatch;
    localparam int unsigned CLK_P = 10;
    localparam int unsigned N     = 4;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned DW    = 8;

    typedef struct packed {
        logic        vin;
        logic [31:0] din;
        logic [3:0]  req;
        logic [3:0]  ev;
        logic [31:0] ed;
    } vec_t;

    // Each row: drive vin/din/req for one cycle, then expect ev/ed after the edge.
    localparam vec_t TBL [11] = '{
        '{1'b1, 32'hA000_0001, 4'b0000, 4'b0000, 32'h0},           // R1 push into empty
        '{1'b1, 32'hA000_0002, 4'b0010, 4'b0010, 32'hA000_0001},   // R7 push+pop, R5 lane 1
        '{1'b0, 32'h0,         4'b0101, 4'b0001, 32'hA000_0002},   // R4 core0 beats core2
        '{1'b0, 32'h0,         4'b0100, 4'b0000, 32'h0},           // R2 empty, pending
        '{1'b1, 32'hA000_0003, 4'b0100, 4'b0000, 32'h0},           // R2 push same cycle: no grant
        '{1'b0, 32'h0,         4'b1100, 4'b0100, 32'hA000_0003},   // R2 pending served, R4
        '{1'b1, 32'hA000_0004, 4'b1000, 4'b0000, 32'h0},           // R2
        '{1'b1, 32'hA000_0005, 4'b1000, 4'b1000, 32'hA000_0004},   // R5 lane 3
        '{1'b0, 32'h0,         4'b0000, 4'b0000, 32'h0},           // R8 single pulse
        '{1'b0, 32'h0,         4'b1111, 4'b0001, 32'hA000_0005},   // R4 all request
        '{1'b0, 32'h0,         4'b1110, 4'b0000, 32'h0}            // R2 drained
    };

    logic                clk = 1'b0;
    logic                rst_n;
    logic [31:0]         in_data;
    logic                in_valid;
    logic                q_full;
    logic [N-1:0]        core_req;
    logic [N*32-1:0]     core_data;
    logic [N-1:0]        core_valid;
    logic [DW-1:0]       drop_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    shq_dispatch #(.N_CORES(N), .DEPTH(DEPTH), .DROP_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .q_full(q_full), .core_req(core_req), .core_data(core_data),
        .core_valid(core_valid), .drop_cnt(drop_cnt)
    );

    task automatic step(input logic vin, input logic [31:0] din, input logic [3:0] req);
        @(negedge clk);
        in_valid = vin;
        in_data  = din;
        core_req = req;
        @(posedge clk);
        #1;
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic [3:0] ev, input logic [31:0] ed);
        checks++;
        if (core_valid !== ev) begin
            errors++;
            $display("FAIL %s valid: got %b expected %b", tag, core_valid, ev);
        end
        for (int i = 0; i < N; i++) begin
            logic [31:0] want;
            want = ev[i] ? ed : 32'h0;
            checks++;
            if (core_data[i*32 +: 32] !== want) begin
                errors++;
                $display("FAIL %s lane %0d: got %h expected %h", tag, i, core_data[i*32 +: 32], want);
            end
        end
    endtask

    task automatic check_drop(input string tag, input logic [DW-1:0] exp);
        checks++;
        if (drop_cnt !== exp) begin
            errors++;
            $display("FAIL %s drop_cnt: got %0d expected %0d", tag, drop_cnt, exp);
        end
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; core_req = '0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check_bit("R9 full", q_full, 1'b0);
        check_out("R9", 4'b0000, 32'h0);
        check_drop("R9", '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R7 R8
        for (int k = 0; k < 11; k++) begin
            step(TBL[k].vin, TBL[k].din, TBL[k].req);
            check_out($sformatf("R3/R5 row %0d", k), TBL[k].ev, TBL[k].ed);
        end

        // R6 fill to DEPTH with no requests
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 32'hD000_0000 + k, 4'b0000);
            check_bit($sformatf("R6 full after %0d", k+1), q_full, (k == DEPTH-1));
        end
        // R6 two words offered while full are dropped
        step(1'b1, 32'hBAD0_0001, 4'b0000);
        check_drop("R6 first drop", 8'd1);
        step(1'b1, 32'hBAD0_0002, 4'b0000);
        check_drop("R6 second drop", 8'd2);
        check_bit("R6 still full", q_full, 1'b1);
        // R6 word offered while full is dropped even with a pop in the same cycle
        step(1'b1, 32'hBAD0_0003, 4'b0001);
        check_out("R6 pop at full", 4'b0001, 32'hD000_0000);
        check_drop("R6 drop during pop", 8'd3);
        check_bit("R6 full released", q_full, 1'b0);
        // R1 drain in order, alternating cores 1 and 0 (R8 withdrawal respected)
        for (int k = 1; k < DEPTH; k++) begin
            logic [3:0] r;
            r = (k % 2 == 1) ? 4'b0010 : 4'b0001;
            step(1'b0, 32'h0, r);
            check_out($sformatf("R1 order %0d", k), r, 32'hD000_0000 + k);
        end
        // R2 queue now empty: request not served
        step(1'b0, 32'h0, 4'b0100);
        check_out("R2 empty after drain", 4'b0000, 32'h0);
        step(1'b0, 32'h0, 4'b0000);
        check_out("R8 idle", 4'b0000, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule